// File: doc/BRIEF.md
# SPI Serial Memory with Region Locking

This block is an SPI slave in front of a byte-wide nonvolatile array of 4096 bytes. The array and the status fields are held in flip-flops. A host can read from any address and stream through the array. It can also write up to one page of 32 bytes per operation. The written bytes gather in a page buffer and are moved into the array by a self-timed write cycle. That cycle starts when chip select rises and lasts a fixed number of clock cycles. During the cycle the status register reports the block as busy.

A two-bit lock code in the status register protects part of the array against writes: nothing, the top quarter, the top half, or everything. A status-lock bit, together with the active-low write-protect pin, can freeze the status register. Every modifying command needs a write-enable latch that was set by an earlier command. The latch clears when a write cycle completes.

The SPI pins are sampled with the system clock, so the serial clock must run at one eighth of the system clock or slower. SPI modes 0 and 3 are both accepted.

Top module: `spimem_top`

## Requirements
- R1: After reset the status register reads 0x00 and every array byte reads 0xFF.
- R2: Opcode 0x03 followed by a 16-bit address (high byte first) returns array bytes MSB first on MISO. The address increments after each byte and wraps from the last byte to address 0. This works in SPI mode 0 and in mode 3.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Both take effect once their eighth bit is received.
- R4: Opcode 0x05 returns the status byte, repeated for as long as clocks continue. Bit 0 is write-in-progress, bit 1 is the write-enable latch, bits 3:2 are the lock code, bit 7 is the status-lock bit, and bits 6:4 read 0.
- R5: A write (opcode 0x02) or a status write issued while the write-enable latch is clear leaves the array and the status unchanged.
- R6: Opcode 0x02 with a 16-bit address and 1 or more data bytes is committed to the array when its write cycle ends. Successive bytes wrap inside the 32-byte page; a later byte at the same position replaces an earlier one. The write-enable latch reads 0 once the cycle ends.
- R7: Write-in-progress reads 1 for the write cycle of WR_CYCLES clocks. During the cycle every command except 0x05 is ignored, and a read issued then returns 0x00 bytes.
- R8: With lock code 00 no address is locked. Code 01 locks 0xC00..0xFFF, code 10 locks 0x800..0xFFF, and code 11 locks all addresses. A write to a locked page starts no cycle, leaves the array unchanged and keeps the write-enable latch set.
- R9: Opcode 0x01 followed by one byte, with the latch set, loads bit 7 and bits 3:2 of that byte into the status register when its write cycle ends.
- R10: While the status-lock bit is 1 and wp_n is low, a status write is ignored and the latch stays set. With wp_n high the status write is accepted.
- R11: A write whose chip select rises part-way through a byte is discarded: no cycle starts and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI pins are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low (mode 0) or high (mode 3) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block, sampled on the rising serial clock edge |
| spi_miso | output | 1 | Serial data out, updated after the falling serial clock edge; 0 when deselected |
| wp_n | input | 1 | Active-low write-protect pin used to freeze the status register |

## Verification
The bench builds the block with ADDR_W 12 and PAGE_W 5, which keeps the full 4096-byte map. With that map the quarter and half boundaries fall at 0xC00 and 0x800, and the wrap from 0xFFF to 0x000 happens at the true end of the array. WR_CYCLES is set to 600 clocks. That is long enough for a status read and a complete read command to land inside a running write cycle, and short enough that a dozen random page writes can each be read back page by page in one run.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    // Transaction phase inside one chip-select window
    typedef enum logic [1:0] {
        PH_OP   = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    // What the running write cycle commits when it ends
    typedef enum logic {
        CYC_ARR = 1'b0,
        CYC_SR  = 1'b1
    } cyc_e;

endpackage

// File: rtl/spimem_pin_sync.sv
module spimem_pin_sync #(
    parameter int           N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] sync_o
);

    // Two flops per pin before any logic looks at it
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        logic stage_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q    <= RST_VAL[gi];
                sync_o[gi] <= RST_VAL[gi];
            end else begin
                stage_q    <= pin_i[gi];
                sync_o[gi] <= stage_q;
            end
        end
    end

endmodule

// File: rtl/spimem_guard.sv
module spimem_guard (
    input  logic [1:0] bp_i,      // lock code from the status register
    input  logic [1:0] region_i,  // two top address bits of the page
    output logic       locked_o
);

    always_comb begin
        unique case (bp_i)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = (region_i == 2'b11);
            2'b10:   locked_o = region_i[1];
            default: locked_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int PAGE  = 1 << PAGE_W,
    localparam int PGA_W = ADDR_W - PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [7:0]            rd_data_o,
    input  logic                  wr_en_i,
    input  logic [PGA_W-1:0]      wr_page_i,
    input  logic [PAGE-1:0][7:0]  wr_data_i,
    input  logic [PAGE-1:0]       wr_mask_i
);

    logic [7:0] mem_q [DEPTH];

    // Whole page lands in one clock; only lanes that were loaded change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (wr_en_i) begin
            for (int i = 0; i < PAGE; i++) begin
                if (wr_mask_i[i]) mem_q[{wr_page_i, PAGE_W'(i)}] <= wr_data_i[i];
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/spimem_top.sv
module spimem_top
    import spimem_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic wp_n
);

    localparam int PAGE  = 1 << PAGE_W;
    localparam int PGA_W = ADDR_W - PAGE_W;
    localparam int HI_W  = ADDR_W - 8;
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic                 sck_p;
        logic                 cs_p;
        phase_e               phase;
        logic [2:0]           bits;
        logic [6:0]           rx;
        logic [7:0]           op;
        logic                 hi_done;
        logic [HI_W-1:0]      addr_hi;
        logic [ADDR_W-1:0]    addr;
        logic [7:0]           tx;
        logic                 miso;
        logic                 wel;
        logic [1:0]           bp;
        logic                 wpen;
        logic                 busy;
        cyc_e                 kind;
        logic [CNT_W-1:0]     cnt;
        logic [PGA_W-1:0]     pg;
        logic [PAGE_W-1:0]    ptr;
        logic [PAGE-1:0][7:0] pbuf;
        logic [PAGE-1:0]      pmask;
        logic                 sr_have;
        logic                 sr_wpen;
        logic [1:0]           sr_bp;
    } st_t;

    st_t q, d;

    logic [3:0] pins_s;
    logic       sck_s, cs_s, sin_s, wp_s;
    logic       sck_rise, sck_fall, cs_rise;
    logic [7:0] byte_in, sr_val, rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic       locked, commit_arr, commit_sr;

    spimem_pin_sync #(.N(4), .RST_VAL(4'b1010)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({wp_n, spi_mosi, spi_cs_n, spi_sck}),
        .sync_o (pins_s)
    );

    assign sck_s = pins_s[0];
    assign cs_s  = pins_s[1];
    assign sin_s = pins_s[2];
    assign wp_s  = pins_s[3];

    assign sck_rise = sck_s && !q.sck_p;
    assign sck_fall = !sck_s && q.sck_p;
    assign cs_rise  = cs_s && !q.cs_p;

    assign byte_in    = {q.rx, sin_s};
    assign sr_val     = {q.wpen, 3'b000, q.bp, q.wel, q.busy};
    assign commit_arr = q.busy && (q.cnt == '0) && (q.kind == CYC_ARR);
    assign commit_sr  = q.busy && (q.cnt == '0) && (q.kind == CYC_SR);
    assign rd_addr    = (q.phase == PH_ADDR) ? {q.addr_hi, byte_in} : q.addr;

    spimem_guard u_guard (
        .bp_i     (q.bp),
        .region_i (q.pg[PGA_W-1 -: 2]),
        .locked_o (locked)
    );

    spimem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_en_i   (commit_arr),
        .wr_page_i (q.pg),
        .wr_data_i (q.pbuf),
        .wr_mask_i (q.pmask)
    );

    always_comb begin
        d       = q;
        d.sck_p = sck_s;
        d.cs_p  = cs_s;

        // Self-timed cycle: count down, commit on the last clock
        if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.wel  = 1'b0;
                if (q.kind == CYC_SR) begin
                    d.bp   = q.sr_bp;
                    d.wpen = q.sr_wpen;
                end
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end

        if (cs_s) begin
            // Deselect: decide on a write cycle from the finished transaction
            if (cs_rise && !q.busy && q.wel && (q.bits == 3'd0)) begin
                if (q.op == OP_WRSR && q.sr_have && !(q.wpen && !wp_s)) begin
                    d.busy = 1'b1;
                    d.kind = CYC_SR;
                    d.cnt  = CNT_W'(WR_CYCLES - 1);
                end else if (q.op == OP_WRITE && q.phase == PH_DATA && (|q.pmask) && !locked) begin
                    d.busy = 1'b1;
                    d.kind = CYC_ARR;
                    d.cnt  = CNT_W'(WR_CYCLES - 1);
                end
            end
            d.phase   = PH_OP;
            d.bits    = '0;
            d.op      = '0;
            d.tx      = '0;
            d.miso    = 1'b0;
            d.sr_have = 1'b0;
        end else if (sck_rise) begin
            d.rx   = byte_in[6:0];
            d.bits = q.bits + 1'b1;
            if (q.bits == 3'd7) begin
                unique case (q.phase)
                    PH_OP: begin
                        d.op = byte_in;
                        if (q.busy && byte_in != OP_RDSR) begin
                            d.phase = PH_SKIP;
                        end else begin
                            unique case (byte_in)
                                OP_WREN: begin d.wel = 1'b1; d.phase = PH_SKIP; end
                                OP_WRDI: begin d.wel = 1'b0; d.phase = PH_SKIP; end
                                OP_RDSR: begin d.tx = sr_val; d.phase = PH_DATA; end
                                OP_WRSR: d.phase = PH_DATA;
                                OP_READ, OP_WRITE: begin
                                    d.phase   = PH_ADDR;
                                    d.hi_done = 1'b0;
                                end
                                default: d.phase = PH_SKIP;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        if (!q.hi_done) begin
                            d.addr_hi = byte_in[HI_W-1:0];
                            d.hi_done = 1'b1;
                        end else begin
                            d.phase = PH_DATA;
                            if (q.op == OP_READ) begin
                                d.tx   = rd_data;
                                d.addr = rd_addr + 1'b1;
                            end else begin
                                d.pg    = rd_addr[ADDR_W-1:PAGE_W];
                                d.ptr   = rd_addr[PAGE_W-1:0];
                                d.pmask = '0;
                            end
                        end
                    end
                    PH_DATA: begin
                        unique case (q.op)
                            OP_READ: begin
                                d.tx   = rd_data;
                                d.addr = q.addr + 1'b1;
                            end
                            OP_RDSR: d.tx = sr_val;
                            OP_WRITE: begin
                                d.pbuf[q.ptr]  = byte_in;
                                d.pmask[q.ptr] = 1'b1;
                                d.ptr          = q.ptr + 1'b1;
                            end
                            default: begin
                                if (!q.sr_have) begin
                                    d.sr_have = 1'b1;
                                    d.sr_wpen = byte_in[7];
                                    d.sr_bp   = byte_in[3:2];
                                end
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
        end else if (sck_fall) begin
            d.miso = q.tx[7];
            d.tx   = {q.tx[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs_p  <= 1'b1;
            q.phase <= PH_OP;
            q.kind  <= CYC_ARR;
        end else begin
            q <= d;
        end
    end

    assign spi_miso = q.miso;

    // A cycle only ever starts with the enable latch set
    p_start_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> q.wel);

    // The latch reads clear once the cycle has ended
    p_wel_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.wel);

    // Cycle counter never exceeds its programmed length
    p_cycle_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt < CNT_W'(WR_CYCLES)));

    // A page inside the locked region never reaches the array
    p_locked_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_arr |-> !locked);

    // Lock code moves only at the end of a status write cycle
    p_bp_only_on_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_sr |=> $stable(q.bp));

    // Status write cycle never starts while frozen by the pin
    p_sr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.busy) && q.kind == CYC_SR) |-> !(q.wpen && !$past(wp_s)));

endmodule

// File: tb/spimem_top_tb_top.sv
module spimem_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 4;
    localparam int AW         = 12;
    localparam int WRC        = 600;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic miso;
    logic mode3 = 1'b0;
    bit   done = 1'b0;

    int checks = 0, fails = 0;

    logic [7:0] model [1 << AW];
    logic [1:0] m_bp   = 2'b00;
    logic       m_wpen = 1'b0;
    logic       m_wel  = 1'b0;
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];

    spimem_top #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WRC)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (sck),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .wp_n     (wp_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic locked_at(logic [1:0] bp, logic [AW-1:0] a);
        return (bp == 2'b11) || (bp == 2'b10 && a[AW-1]) || (bp == 2'b01 && a[AW-1:AW-2] == 2'b11);
    endfunction

    function automatic logic [7:0] exp_sr();
        return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cs_lo();
        sck = mode3;
        tick(H);
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic cs_hi();
        tick(H);
        cs_n = 1'b1;
        tick(2*H);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            if (mode3) sck = 1'b0;
            mosi = tx[i];
            tick(H);
            rx[i] = miso;
            sck = 1'b1;
            tick(H);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo(); xbyte(op, r); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        cs_lo(); xbyte(8'h05, r); xbyte(8'h00, s); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        cs_lo(); xbyte(8'h01, r); xbyte(v, r); cs_hi();
    endtask

    task automatic write_pg(input logic [15:0] a, input int n);
        logic [7:0] r;
        cs_lo(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int k = 0; k < n; k++) xbyte(wbuf[k], r);
        cs_hi();
    endtask

    task automatic read_mem(input logic [15:0] a, input int n);
        logic [7:0] r;
        cs_lo(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int k = 0; k < n; k++) xbyte(8'h00, rbuf[k]);
        cs_hi();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic model_write(input logic [AW-1:0] a, input int n);
        if (m_wel && !locked_at(m_bp, a)) begin
            for (int k = 0; k < n; k++) model[{a[AW-1:5], 5'(a[4:0] + k)}] = wbuf[k];
            m_wel = 1'b0;
        end
    endtask

    task automatic check_page(input string req, input logic [AW-1:0] a);
        read_mem({4'h0, a[AW-1:5], 5'd0}, 32);
        for (int k = 0; k < 32; k++)
            check(req, "page byte", rbuf[k], model[{a[AW-1:5], 5'(k)}]);
    endtask

    task automatic set_bp(input logic [7:0] v);
        cmd1(8'h06);
        wrsr(v);
        wait_idle();
        m_wel = 1'b0; m_bp = v[3:2]; m_wpen = v[7];
    endtask

    initial begin
        tick(CLK_PERIOD * 0 + 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, s2;
        logic [7:0] r;
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        rdsr(s);
        check("R1", "status after reset", s, 8'h00);
        read_mem(16'h0000, 4);
        for (int k = 0; k < 4; k++) check("R1", "array after reset", rbuf[k], 8'hFF);

        // R3 / R4 latch set and clear, status repeats
        cmd1(8'h06);
        cs_lo(); xbyte(8'h05, r); xbyte(8'h00, s); xbyte(8'h00, s2); cs_hi();
        check("R3", "status after set", s, 8'h02);
        check("R4", "status repeated", s2, 8'h02);
        cmd1(8'h04);
        rdsr(s);
        check("R3", "status after clear", s, 8'h00);

        // R5 write without latch
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h30 + 8'(k);
        write_pg(16'h0100, 4);
        rdsr(s);
        check("R5", "no cycle without latch", s, 8'h00);
        read_mem(16'h0100, 4);
        for (int k = 0; k < 4; k++) check("R5", "array untouched", rbuf[k], 8'hFF);

        // R6 / R7 page write with wrap, busy behaviour
        cmd1(8'h06); m_wel = 1'b1;
        for (int k = 0; k < 6; k++) wbuf[k] = 8'hA0 + 8'(k);
        write_pg(16'h011D, 6);
        model_write(12'h11D, 6);
        rdsr(s);
        check("R7", "status during cycle", s, 8'h03);
        read_mem(16'h011D, 1);
        check("R7", "read during cycle", rbuf[0], 8'h00);
        wait_idle();
        rdsr(s);
        check("R6", "latch clear after cycle", s, 8'h00);
        check_page("R6", 12'h100);

        // R2 end-of-array wrap, read in mode 3
        cmd1(8'h06); m_wel = 1'b1;
        wbuf[0] = 8'hA5; write_pg(16'h0FFF, 1); model_write(12'hFFF, 1); wait_idle();
        cmd1(8'h06); m_wel = 1'b1;
        wbuf[0] = 8'h5A; write_pg(16'h0000, 1); model_write(12'h000, 1); wait_idle();
        mode3 = 1'b1;
        read_mem(16'h0FFF, 2);
        check("R2", "mode3 last byte", rbuf[0], 8'hA5);
        check("R2", "mode3 wrap to zero", rbuf[1], 8'h5A);
        mode3 = 1'b0;
        read_mem(16'h0FFF, 2);
        check("R2", "mode0 wrap to zero", rbuf[1], 8'h5A);

        // R8 / R9 lock codes
        set_bp(8'h04);
        rdsr(s);
        check("R9", "lock code 01 loaded", s, 8'h04);
        cmd1(8'h06); m_wel = 1'b1;
        wbuf[0] = 8'h11; write_pg(16'h0C10, 1); model_write(12'hC10, 1);
        rdsr(s);
        check("R8", "locked write keeps latch", s, 8'h06);
        read_mem(16'h0C10, 1);
        check("R8", "quarter locked", rbuf[0], 8'hFF);
        wbuf[0] = 8'h22; write_pg(16'h0BF0, 1); model_write(12'hBF0, 1); wait_idle();
        read_mem(16'h0BF0, 1);
        check("R8", "below quarter writable", rbuf[0], 8'h22);
        set_bp(8'h08);
        cmd1(8'h06); m_wel = 1'b1;
        wbuf[0] = 8'h33; write_pg(16'h0800, 1); model_write(12'h800, 1);
        read_mem(16'h0800, 1);
        check("R8", "half locked", rbuf[0], 8'hFF);
        write_pg(16'h07F0, 1); model_write(12'h7F0, 1); wait_idle();
        read_mem(16'h07F0, 1);
        check("R8", "below half writable", rbuf[0], 8'h33);
        set_bp(8'h0C);
        cmd1(8'h06); m_wel = 1'b1;
        wbuf[0] = 8'h44; write_pg(16'h0000, 1); model_write(12'h000, 1);
        read_mem(16'h0000, 1);
        check("R8", "all locked", rbuf[0], 8'h5A);
        cmd1(8'h04); m_wel = 1'b0;

        // R10 status freeze by pin
        set_bp(8'h80);
        rdsr(s);
        check("R10", "status lock bit set", s, 8'h80);
        wp_n = 1'b0;
        cmd1(8'h06);
        wrsr(8'h0C);
        rdsr(s);
        check("R10", "frozen status write ignored", s, 8'h82);
        wp_n = 1'b1;
        wrsr(8'h00);
        wait_idle();
        m_wpen = 1'b0; m_bp = 2'b00; m_wel = 1'b0;
        rdsr(s);
        check("R10", "unfrozen status write", s, 8'h00);

        // R11 partial final byte
        cmd1(8'h06);
        cs_lo(); xbyte(8'h02, r); xbyte(8'h01, r); xbyte(8'h40, r); xbyte(8'h77, r); xbits(8'hF0, 4, r); cs_hi();
        rdsr(s);
        check("R11", "no cycle on partial byte", s, 8'h02);
        read_mem(16'h0140, 1);
        check("R11", "array untouched", rbuf[0], 8'hFF);
        cmd1(8'h04);

        // R6 / R8 random page writes with random lock codes and modes
        for (int it = 0; it < 12; it++) begin
            logic [AW-1:0] a;
            int n;
            a = AW'($urandom % (1 << AW));
            n = 1 + int'($urandom % 36);
            mode3 = 1'($urandom % 2);
            if ($urandom % 3 == 0) set_bp({4'h0, 2'($urandom % 4), 2'b00});
            if ($urandom % 4 != 0) begin cmd1(8'h06); m_wel = 1'b1; end
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            write_pg({4'h0, a}, n);
            model_write(a, n);
            wait_idle();
            rdsr(s);
            check("R8", "random status", s, exp_sr());
            check_page("R6", a);
        end
        mode3 = 1'b0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule